// File: doc/BRIEF.md
# Cipher Input Block Stager

The stager sits in front of a block-cipher engine and shapes a stream of 32-bit words into the transfers the engine expects. Each accepted word first has the byte order inside it reversed. Outside the engine's payload phase, the words collect in a staging buffer the size of one cipher block. The buffer is handed to the engine as a single multi-word transfer.

The first 16 bytes of every message are the initialisation vector. They always leave as a transfer of their own, and that transfer is marked last at the moment the running byte count reaches 16. If an end-of-packet cuts the vector short, the partial vector is flushed unmarked. The next flush then waits only for the words still missing from the vector. After the vector, data keeps being packed into whole blocks while the engine is outside its payload phase. Once the engine is in payload and the buffer is empty, each word goes straight through on its own.

The stager counts the bytes it has delivered since message start. In encrypt mode it raises a sticky warning once that count exceeds 32. Results coming back from the engine have their byte order reversed again on the way out.

Top module: `cipher_in_stager`

## Requirements
- R1: Every word delivered to the engine is the accepted input word with its four bytes in reverse order (input byte 0, bits 7:0, lands in bits 31:24). The first word of a transfer sits in `out_data_o[31:0]`, the next in `[63:32]`, and so on. Word slots beyond `out_nwords_o` read as zero.
- R2: `res_data_o` is `res_data_i` with the four bytes of the word reversed, and `res_valid_o` equals `res_valid_i`, both combinationally.
- R3: `in_ready_o` equals `eng_ready_i`. A beat presented while `eng_ready_i` is low is not taken: it produces no transfer and leaves the byte count unchanged.
- R4: From an empty message, four non-payload beats without end-of-packet produce one four-word transfer with `out_last_o`=1, and the byte count becomes 16.
- R5: While the byte count is below 16, a staged end-of-packet flushes the partial buffer with `out_last_o`=0 unless the count then reaches exactly 16. The next flush happens as soon as the buffer holds (16 - count)/4 words, and that transfer is marked last.
- R6: Once the count is at least 16 and the engine is outside payload, words are packed into four-word transfers. An end-of-packet flushes a shorter transfer early, and `out_last_o` equals the end-of-packet flag of the beat that caused the flush.
- R7: When `payload_i` is high, the count is at least 16 and the buffer is empty, each accepted word is sent alone (`out_nwords_o`=1) with `out_last_o` equal to its end-of-packet flag.
- R8: When `payload_i` is high but the buffer is partly filled or the count is below 16, words are still staged as in R4 to R6.
- R9: `byte_cnt_o` holds the bytes delivered since message start and updates in the same cycle as the transfer that delivers them. A `msg_start_i` pulse clears it.
- R10: With `encrypt_i` high at message start, `warn_o` rises with the first transfer that takes the count above 32. It stays high until the next `msg_start_i`. It never rises in a message started with `encrypt_i` low.
- R11: A transfer appears on `out_valid_o` for exactly the cycle after the clock edge that accepted the beat that triggered it.
- R12: After reset, `out_valid_o`, `byte_cnt_o` and `warn_o` are zero and the staging buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_start_i | input | 1 | Start of a new message: clears count, buffer and warning |
| encrypt_i | input | 1 | Mode sampled at message start: 1 encrypt, 0 decrypt |
| payload_i | input | 1 | Engine is in its payload phase |
| eng_ready_i | input | 1 | Engine can take input |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Input word |
| in_eop_i | input | 1 | Input word ends a packet |
| in_ready_o | output | 1 | Input word accepted when high with in_valid_i |
| out_valid_o | output | 1 | Transfer to the engine this cycle |
| out_data_o | output | 128 | Transfer words, first word in the low bits |
| out_nwords_o | output | 3 | Number of words in the transfer |
| out_last_o | output | 1 | Transfer is marked last |
| byte_cnt_o | output | 12 | Bytes delivered since message start (saturating) |
| warn_o | output | 1 | Sticky over-length warning in encrypt mode |
| res_valid_i | input | 1 | Engine result valid |
| res_data_i | input | 32 | Engine result word |
| res_valid_o | output | 1 | Result valid out |
| res_data_o | output | 32 | Result word with byte order reversed |

## Verification
The hardest state to reach from the ports is a partial vector. A message must end inside its first 16 bytes while more words are still to come, so that the next flush threshold is neither four words nor tied to an end-of-packet. Related cases need `payload_i` to rise while the buffer still holds words. The bench reaches all of these by sweeping the message length, and the beat at which `payload_i` turns on, across every combination of a small range in both modes. A directed sequence covers two-word packets inside the vector. Every beat is compared against an arithmetic model of count, fill and flags.

// File: rtl/cis_pkg.sv
package cis_pkg;
  localparam int DEF_DATA_W     = 32;
  localparam int DEF_BLK_WORDS  = 4;
  localparam int DEF_IV_BYTES   = 16;
  localparam int DEF_CNT_W      = 12;
  localparam int DEF_WARN_LIMIT = 32;
endpackage

// File: rtl/cis_byte_rev.sv
module cis_byte_rev #(
  parameter int W = 32
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  localparam int NB = W / 8;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign d_o[g*8 +: 8] = d_i[(NB-1-g)*8 +: 8];
  end
endmodule

// File: rtl/cis_len_track.sv
module cis_len_track #(
  parameter int CNT_W      = 12,
  parameter int IV_BYTES   = 16,
  parameter int WORD_BYTES = 4,
  parameter int BLK_WORDS  = 4,
  parameter int WARN_LIMIT = 32,
  parameter int NW_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             encrypt_i,
  input  logic             emit_i,
  input  logic [CNT_W-1:0] emit_bytes_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             iv_done_o,
  output logic             reach_iv_o,
  output logic [NW_W-1:0]  need_o,
  output logic             warn_o
);
  localparam logic [CNT_W-1:0] IV_C = CNT_W'(IV_BYTES);
  localparam logic [CNT_W-1:0] WL_C = CNT_W'(WARN_LIMIT);
  localparam logic [CNT_W-1:0] WB_C = CNT_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0] BW_C = CNT_W'(BLK_WORDS);

  logic [CNT_W-1:0] cnt_q, cnt_eff, cnt_nxt, rem_w;
  logic [CNT_W:0]   sum;
  logic             enc_q, enc_eff, warn_q, warn_nxt;

  always_comb begin
    cnt_eff   = start_i ? '0 : cnt_q;
    enc_eff   = start_i ? encrypt_i : enc_q;
    iv_done_o = cnt_eff >= IV_C;
    rem_w     = (IV_C - cnt_eff) / WB_C;
    if (iv_done_o || rem_w > BW_C) need_o = NW_W'(BLK_WORDS);
    else                           need_o = NW_W'(rem_w);
    sum        = {1'b0, cnt_eff} + {1'b0, emit_bytes_i};
    cnt_nxt    = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    reach_iv_o = !iv_done_o && (sum == {1'b0, IV_C});
    warn_nxt   = (warn_q & ~start_i) | (emit_i & enc_eff & (cnt_nxt > WL_C));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      enc_q  <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      cnt_q  <= emit_i ? cnt_nxt : cnt_eff;
      enc_q  <= enc_eff;
      warn_q <= warn_nxt;
    end
  end

  assign cnt_o  = cnt_q;
  assign warn_o = warn_q;

  a_r9_cnt_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> cnt_q >= $past(cnt_q));
  a_r10_warn_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_q && !start_i |=> warn_q);
  a_r10_warn_needs_enc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_q |-> enc_q);
endmodule

// File: rtl/cis_stage_buf.sv
module cis_stage_buf #(
  parameter int W         = 32,
  parameter int BLK_WORDS = 4,
  parameter int NW_W      = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   push_i,
  input  logic [W-1:0]           word_i,
  input  logic                   eop_i,
  input  logic [NW_W-1:0]        thresh_i,
  output logic [NW_W-1:0]        fill_o,
  output logic                   flush_o,
  output logic [BLK_WORDS*W-1:0] blk_o,
  output logic [NW_W-1:0]        nwords_o
);
  logic [W-1:0]    buf_q [BLK_WORDS];
  logic [NW_W-1:0] fill_q, fill_eff, new_fill;

  always_comb begin
    fill_eff = start_i ? '0 : fill_q;
    new_fill = fill_eff + 1'b1;
    flush_o  = push_i && ((new_fill >= thresh_i) || eop_i);
  end

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                             buf_q[i] <= '0;
      else if (push_i && !flush_o && fill_eff == NW_W'(i)) buf_q[i] <= word_i;
    end
    assign blk_o[i*W +: W] = (NW_W'(i) < fill_eff) ? buf_q[i] :
                             ((NW_W'(i) == fill_eff) && push_i) ? word_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 fill_q <= '0;
    else if (push_i && !flush_o) fill_q <= new_fill;
    else if (flush_o || start_i) fill_q <= '0;
  end

  assign fill_o   = fill_eff;
  assign nwords_o = new_fill;

  a_r8_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q < NW_W'(BLK_WORDS));
  a_r6_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> fill_q == '0);
endmodule

// File: rtl/cipher_in_stager.sv
module cipher_in_stager #(
  parameter int DATA_W     = cis_pkg::DEF_DATA_W,
  parameter int BLK_WORDS  = cis_pkg::DEF_BLK_WORDS,
  parameter int IV_BYTES   = cis_pkg::DEF_IV_BYTES,
  parameter int CNT_W      = cis_pkg::DEF_CNT_W,
  parameter int WARN_LIMIT = cis_pkg::DEF_WARN_LIMIT
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        msg_start_i,
  input  logic                        encrypt_i,
  input  logic                        payload_i,
  input  logic                        eng_ready_i,
  input  logic                        in_valid_i,
  input  logic [DATA_W-1:0]           in_data_i,
  input  logic                        in_eop_i,
  output logic                        in_ready_o,
  output logic                        out_valid_o,
  output logic [BLK_WORDS*DATA_W-1:0] out_data_o,
  output logic [$clog2(BLK_WORDS+1)-1:0] out_nwords_o,
  output logic                        out_last_o,
  output logic [CNT_W-1:0]            byte_cnt_o,
  output logic                        warn_o,
  input  logic                        res_valid_i,
  input  logic [DATA_W-1:0]           res_data_i,
  output logic                        res_valid_o,
  output logic [DATA_W-1:0]           res_data_o
);
  localparam int WB    = DATA_W / 8;
  localparam int NW_W  = $clog2(BLK_WORDS + 1);
  localparam int BLK_W = BLK_WORDS * DATA_W;

  logic [DATA_W-1:0] in_sw;
  logic              acc, bypass, st_push, st_flush, emit, last_nxt;
  logic              iv_done, reach_iv;
  logic [NW_W-1:0]   st_fill, st_nwords, need;
  logic [BLK_W-1:0]  st_blk;
  logic [CNT_W-1:0]  emit_bytes;

  logic              out_valid_q, out_last_q;
  logic [BLK_W-1:0]  out_data_q;
  logic [NW_W-1:0]   out_nwords_q;

  cis_byte_rev #(.W(DATA_W)) u_rev_in  (.d_i(in_data_i),  .d_o(in_sw));
  cis_byte_rev #(.W(DATA_W)) u_rev_out (.d_i(res_data_i), .d_o(res_data_o));
  assign res_valid_o = res_valid_i;

  assign in_ready_o = eng_ready_i;
  assign acc        = in_valid_i & eng_ready_i;
  assign bypass     = payload_i && (st_fill == '0) && iv_done;
  assign st_push    = acc & ~bypass;
  assign emit       = st_flush | (acc & bypass);
  assign emit_bytes = bypass ? CNT_W'(WB) : CNT_W'(st_nwords) * CNT_W'(WB);
  assign last_nxt   = iv_done ? in_eop_i : reach_iv;

  cis_stage_buf #(.W(DATA_W), .BLK_WORDS(BLK_WORDS), .NW_W(NW_W)) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (msg_start_i),
    .push_i   (st_push),
    .word_i   (in_sw),
    .eop_i    (in_eop_i),
    .thresh_i (need),
    .fill_o   (st_fill),
    .flush_o  (st_flush),
    .blk_o    (st_blk),
    .nwords_o (st_nwords)
  );

  cis_len_track #(
    .CNT_W(CNT_W), .IV_BYTES(IV_BYTES), .WORD_BYTES(WB),
    .BLK_WORDS(BLK_WORDS), .WARN_LIMIT(WARN_LIMIT), .NW_W(NW_W)
  ) u_len (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (msg_start_i),
    .encrypt_i    (encrypt_i),
    .emit_i       (emit),
    .emit_bytes_i (emit_bytes),
    .cnt_o        (byte_cnt_o),
    .iv_done_o    (iv_done),
    .reach_iv_o   (reach_iv),
    .need_o       (need),
    .warn_o       (warn_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q  <= 1'b0;
      out_last_q   <= 1'b0;
      out_data_q   <= '0;
      out_nwords_q <= '0;
    end else begin
      out_valid_q <= emit;
      if (emit) begin
        out_data_q   <= bypass ? BLK_W'(in_sw) : st_blk;
        out_nwords_q <= bypass ? NW_W'(1) : st_nwords;
        out_last_q   <= last_nxt;
      end
    end
  end

  assign out_valid_o  = out_valid_q;
  assign out_data_o   = out_data_q;
  assign out_nwords_o = out_nwords_q;
  assign out_last_o   = out_last_q;

  a_r4_iv_last_at_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o && byte_cnt_o <= CNT_W'(IV_BYTES) |-> byte_cnt_o == CNT_W'(IV_BYTES));
  a_r11_words_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_nwords_o != '0 && out_nwords_o <= NW_W'(BLK_WORDS));
  a_r3_emit_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_ready_i |=> !out_valid_o);
endmodule

// File: tb/test_cipher_in_stager.sv
`timescale 1ns/1ps
module test_cipher_in_stager;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         msg_start = 0, encrypt = 0, payload = 0, eng_ready = 1;
  logic         in_valid = 0, in_eop = 0, in_ready;
  logic [31:0]  in_data = '0;
  logic         out_valid, out_last, warn, res_valid_i = 0, res_valid_o;
  logic [127:0] out_data;
  logic [2:0]   out_nwords;
  logic [11:0]  byte_cnt;
  logic [31:0]  res_data_i = '0, res_data_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model
  int          m_fill, m_cnt;
  bit          m_warn, m_enc;
  logic [31:0] m_buf [4];

  always #2.5 clk = ~clk;

  cipher_in_stager i_cipher_in_stager (
    .clk_i(clk), .rst_ni(rst_n), .msg_start_i(msg_start), .encrypt_i(encrypt),
    .payload_i(payload), .eng_ready_i(eng_ready), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_eop_i(in_eop), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_nwords_o(out_nwords),
    .out_last_o(out_last), .byte_cnt_o(byte_cnt), .warn_o(warn),
    .res_valid_i(res_valid_i), .res_data_i(res_data_i),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o)
  );

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
  endtask

  // caller is at a negedge
  task automatic start_msg(input bit enc);
    msg_start = 1; encrypt = enc;
    @(negedge clk);
    msg_start = 0;
    m_fill = 0; m_cnt = 0; m_warn = 0; m_enc = enc;
    chk(byte_cnt == 0, "R9 count cleared", 128'(byte_cnt), 0);
    chk(warn == 0, "R10 warn cleared", 128'(warn), 0);
    chk(out_valid == 0, "R11 idle start", 128'(out_valid), 0);
  endtask

  task automatic beat(input logic [31:0] d, input bit eop, input bit pay);
    logic [127:0] e_data;
    int e_n, pre;
    bit e_emit, e_last, ivd;
    logic [31:0] sw;
    in_valid = 1; in_data = d; in_eop = eop; payload = pay; eng_ready = 1;
    sw = rev(d);
    e_data = '0; e_n = 0; e_emit = 0; e_last = 0;
    ivd = m_cnt >= 16;
    pre = m_cnt;
    if (pay && m_fill == 0 && ivd) begin           // R7
      e_emit = 1; e_n = 1; e_data[31:0] = sw; e_last = eop;
    end else begin                                   // R4 R5 R6 R8
      m_buf[m_fill] = sw; m_fill++;
      if (m_fill >= (ivd ? 4 : (16 - m_cnt) / 4) || eop) begin
        e_emit = 1; e_n = m_fill;
        for (int i = 0; i < m_fill; i++) e_data[i*32 +: 32] = m_buf[i];
        e_last = ivd ? eop : (m_cnt + 4 * m_fill == 16);
        m_fill = 0;
      end
    end
    if (e_emit) begin
      m_cnt += 4 * e_n;
      if (m_enc && m_cnt > 32) m_warn = 1;
    end
    @(negedge clk);
    in_valid = 0; in_eop = 0;
    chk(out_valid == e_emit, "R11 transfer timing", 128'(out_valid), 128'(e_emit));
    if (e_emit && out_valid) begin
      chk(out_data == e_data, "R1 transfer data", out_data, e_data);
      chk(out_nwords == 3'(e_n), pay ? "R7 R8 word count" : "R6 word count",
          128'(out_nwords), 128'(e_n));
      chk(out_last == e_last, pre < 16 ? "R5 last flag" : "R6 last flag",
          128'(out_last), 128'(e_last));
    end
    chk(byte_cnt == 12'(m_cnt), "R9 byte count", 128'(byte_cnt), 128'(m_cnt));
    chk(warn == m_warn, "R10 warning", 128'(warn), 128'(m_warn));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(out_valid == 0, "R12 out_valid", 128'(out_valid), 0);
    chk(byte_cnt == 0, "R12 count", 128'(byte_cnt), 0);
    chk(warn == 0, "R12 warn", 128'(warn), 0);
    rst_n = 1;
    @(negedge clk);
    m_fill = 0; m_cnt = 0; m_warn = 0; m_enc = 0;

    // R3 ready follows engine, no beat taken without it
    eng_ready = 0; #1;
    chk(in_ready == 0, "R3 ready low", 128'(in_ready), 0);
    eng_ready = 1; #1;
    chk(in_ready == 1, "R3 ready high", 128'(in_ready), 1);
    @(negedge clk);
    start_msg(1'b0);
    eng_ready = 0; in_valid = 1; in_data = 32'hDEADBEEF; in_eop = 1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid == 0, "R3 stalled no transfer", 128'(out_valid), 0);
      chk(byte_cnt == 0, "R3 stalled count", 128'(byte_cnt), 0);
    end
    in_valid = 0; in_eop = 0; eng_ready = 1;

    // R2 result path
    for (int k = 0; k < 8; k++) begin
      res_data_i = 32'h0F1E2D3C + 32'h11335577 * k; res_valid_i = k[0]; #1;
      chk(res_data_o == rev(res_data_i), "R2 result bytes", 128'(res_data_o), 128'(rev(res_data_i)));
      chk(res_valid_o == res_valid_i, "R2 result valid", 128'(res_valid_o), 128'(res_valid_i));
    end
    @(negedge clk);

    // R5 directed: vector split by an early end of packet
    start_msg(1'b0);
    beat(32'hA0A1A2A3, 0, 0);
    beat(32'hB0B1B2B3, 1, 0);
    chk(byte_cnt == 8 && out_last == 0, "R5 partial vector unmarked", 128'(byte_cnt), 8);
    beat(32'hC0C1C2C3, 0, 0);
    beat(32'hD0D1D2D3, 0, 0);
    chk(byte_cnt == 16 && out_last == 1 && out_nwords == 2, "R5 vector completes",
        {out_nwords, out_last, byte_cnt}, {3'd2, 1'b1, 12'd16});
    beat(32'hE0E1E2E3, 1, 1);

    // sweep: mode x length x payload onset
    for (int enc = 0; enc < 2; enc++)
      for (int len = 1; len <= 12; len++)
        for (int p = 0; p <= len; p++) begin
          start_msg(enc[0]);
          for (int k = 0; k < len; k++)
            beat({8'(len), 8'(k), 8'(p + 8'h5A), 8'(~k)}, k == len - 1, k >= p);
        end

    // R12 reset mid message
    start_msg(1'b1);
    for (int k = 0; k < 6; k++) beat(32'h13572468 + k, 0, 0);
    rst_n = 0;
    @(negedge clk);
    chk(byte_cnt == 0 && out_valid == 0, "R12 reset mid message", 128'(byte_cnt), 0);
    rst_n = 1;
    @(negedge clk);
    m_fill = 0; m_cnt = 0; m_warn = 0; m_enc = 0;
    for (int k = 0; k < 4; k++) beat(32'h2468ACE0 + k, 0, 0);
    chk(out_last == 1 && byte_cnt == 16, "R4 vector after reset", 128'(byte_cnt), 16);

    summary();
    $finish;
  end
endmodule